// File: doc/BRIEF.md
# Floppy Controller Forced Interrupt Unit

This unit handles the forced-interrupt command of a floppy disk controller. A command byte whose upper nibble is 4'hD is taken whenever it is written, even while the command sequencer is busy with another command. If a command is running at that moment, the unit asks the sequencer to abort it. The abort is issued only in a cycle in which the sequencer reports that no arithmetic work, such as a CRC update or a compare, is still in progress.

The low nibble of the command selects the interrupt sources. Three of its bits arm persistent conditions on the drive's ready and index inputs. The fourth bit raises the interrupt request at once. An immediate interrupt stays set through status reads and command writes. It is released only after a forced interrupt with no condition bits has been written.

After each forced interrupt a settling window starts. Its length depends on the recording density. Any other command written inside this window cancels the forced interrupt and sets a status flag.

Top module: `fdc_force_irq`

## Requirements
- R1: A write with `cmd_data[7:4] == 4'hD` is accepted in any cycle. When `seq_busy` is high in the write cycle, an abort becomes pending. When `seq_busy` is low, no abort is issued.
- R2: `abort_o` is high only in a cycle where an abort is pending and `alu_idle` is high. It lasts exactly one cycle, after which the abort is no longer pending.
- R3: `cmd_data[3]` set in a forced-interrupt write drives `irq_o` high from the next clock edge.
- R4: `cmd_data[0]` arms a rising edge of `ready_in` and `cmd_data[1]` arms a falling edge. `irq_o` rises on the third clock edge after the input changes.
- R5: `cmd_data[2]` arms the rising edge of `index_in`. Every pulse fires once, with the same three-edge delay. A level held high does not fire again, and a falling edge does not fire.
- R6: The armed conditions are ORed together. They stay armed until the next forced-interrupt write or until the command is cancelled.
- R7: Code 8'hD0 arms nothing and raises no interrupt. It still aborts a busy command as in R1.
- R8: When no immediate interrupt is held, a status read or any command write clears `irq_o` at the next edge. A new interrupt in the same cycle takes priority over the clear.
- R9: After a write with `cmd_data[3]` set, the interrupt is held against clearing. Only a write of 8'hD0 releases the hold, and that write does not clear `irq_o` itself. The next read or command write does.
- R10: A forced-interrupt write starts a window of `GUARD_DD_CYC` cycles when `dbl_density` is 1, or `GUARD_SD_CYC` cycles when it is 0. A non-0xD command written on edges 1 to N after that write sets `nullified_o`, disarms all conditions and cancels any pending abort. Such a write on edge N+1 or later does none of these things.
- R11: After reset, `irq_o`, `abort_o` and `nullified_o` are low and no condition is armed. `nullified_o` is cleared by the next forced-interrupt write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command byte |
| status_rd | input | 1 | Status register read strobe |
| seq_busy | input | 1 | Sequencer is executing a command |
| alu_idle | input | 1 | Sequencer has no arithmetic step in progress |
| ready_in | input | 1 | Drive ready, asynchronous |
| index_in | input | 1 | Index pulse, asynchronous |
| dbl_density | input | 1 | 1 selects double-density settling window |
| abort_o | output | 1 | One-cycle abort request to the sequencer |
| irq_o | output | 1 | Interrupt request |
| nullified_o | output | 1 | The last forced interrupt was cancelled by an early command |

## Verification
The results arrive at different times:
- `abort_o` is combinational from the pending state and `alu_idle`. The bench checks it 1 ns after it drives `alu_idle` high, and again one cycle later to confirm it has dropped.
- An immediate interrupt, a clear and the nullify flag each appear one edge after the strobe. The bench drives the strobe on a falling edge and samples at the next falling edge.
- Ready and index events pass through two synchroniser stages and an edge register, so the bench samples `irq_o` three falling edges after it changes the input.
- The settling window is checked at both sides of its boundary, N-1 and N idle cycles after the forced write, for both densities.

// File: rtl/fdc_force_irq.sv
module fdc_force_irq #(
  parameter int GUARD_DD_CYC = 16,
  parameter int GUARD_SD_CYC = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       status_rd,
  input  logic       seq_busy,
  input  logic       alu_idle,
  input  logic       ready_in,
  input  logic       index_in,
  input  logic       dbl_density,
  output logic       abort_o,
  output logic       irq_o,
  output logic       nullified_o
);
  localparam int GMAX = (GUARD_SD_CYC > GUARD_DD_CYC) ? GUARD_SD_CYC : GUARD_DD_CYC;
  localparam int GW   = $clog2(GMAX + 1);

  logic [2:0]    rdy_sh, idx_sh;
  logic [2:0]    arm_q;
  logic [GW-1:0] guard_q;
  logic          pend_q, sticky_q;

  wire force_wr = cmd_we && (cmd_data[7:4] == 4'hD);
  wire other_wr = cmd_we && !force_wr;
  wire early    = other_wr && (guard_q != '0);
  wire rdy_rise = rdy_sh[1] & ~rdy_sh[2];
  wire rdy_fall = ~rdy_sh[1] & rdy_sh[2];
  wire idx_rise = idx_sh[1] & ~idx_sh[2];
  wire event_hit = (arm_q[0] & rdy_rise) | (arm_q[1] & rdy_fall) | (arm_q[2] & idx_rise);
  wire set_irq  = event_hit | (force_wr & cmd_data[3]);
  wire clr_irq  = (status_rd | cmd_we) & ~sticky_q;

  assign abort_o = pend_q & alu_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_sh      <= '0;
      idx_sh      <= '0;
      arm_q       <= '0;
      guard_q     <= '0;
      pend_q      <= 1'b0;
      sticky_q    <= 1'b0;
      irq_o       <= 1'b0;
      nullified_o <= 1'b0;
    end else begin
      rdy_sh <= {rdy_sh[1:0], ready_in};
      idx_sh <= {idx_sh[1:0], index_in};

      if (force_wr)
        guard_q <= dbl_density ? GW'(GUARD_DD_CYC) : GW'(GUARD_SD_CYC);
      else if (guard_q != '0)
        guard_q <= guard_q - 1'b1;

      if (force_wr)   arm_q <= cmd_data[2:0];
      else if (early) arm_q <= '0;

      if (force_wr)                pend_q <= seq_busy;
      else if (early || abort_o)   pend_q <= 1'b0;

      if (force_wr)   nullified_o <= 1'b0;
      else if (early) nullified_o <= 1'b1;

      if (force_wr && cmd_data[3])               sticky_q <= 1'b1;
      else if (force_wr && cmd_data[3:0] == 4'h0) sticky_q <= 1'b0;

      if (set_irq)      irq_o <= 1'b1;
      else if (clr_irq) irq_o <= 1'b0;
    end
  end

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && !force_wr) |=> !abort_o); // R2
  AST_IMMEDIATE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_wr && cmd_data[3]) |=> irq_o); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && irq_o) |=> irq_o); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !sticky_q && !set_irq) |=> !irq_o); // R8
  AST_NO_SPONTANEOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !set_irq) |=> !irq_o); // R7
  AST_NULLIFY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> (arm_q == '0 && !pend_q && nullified_o)); // R10
  AST_GUARD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_q != '0 && !force_wr) |=> (guard_q == $past(guard_q) - 1'b1)); // R10
endmodule

// File: tb/fdc_force_irq_tb_top.sv
module fdc_force_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0, status_rd = 1'b0, seq_busy = 1'b0, alu_idle = 1'b0;
  logic ready_in = 1'b0, index_in = 1'b0, dbl_density = 1'b1;
  logic [7:0] cmd_data = 8'h00;
  logic abort_o, irq_o, nullified_o;
  int checks = 0, fails = 0;

  localparam int NDD = 4;
  localparam int NSD = 8;

  always #5 clk = ~clk;

  fdc_force_irq #(.GUARD_DD_CYC(NDD), .GUARD_SD_CYC(NSD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .status_rd(status_rd), .seq_busy(seq_busy), .alu_idle(alu_idle),
    .ready_in(ready_in), .index_in(index_in), .dbl_density(dbl_density),
    .abort_o(abort_o), .irq_o(irq_o), .nullified_o(nullified_o));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    cmd_we = 1'b1; cmd_data = b;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic rd();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic guard_case(input logic dbl, input int m, input logic exp_null);
    dbl_density = dbl; seq_busy = 1'b1; alu_idle = 1'b0;
    wr(8'hD1);
    waitn(m);
    wr(8'h00);
    chk("R10 nullified flag", nullified_o, exp_null);
    alu_idle = 1'b1; #1;
    chk("R10 pending abort after early write", abort_o, !exp_null);
    waitn(1);
    alu_idle = 1'b0; seq_busy = 1'b0;
    ready_in = 1'b1; waitn(3);
    chk("R10 arming after early write", irq_o, !exp_null);
    ready_in = 1'b0; waitn(3);
    rd();
    waitn(NSD + 2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    chk("R11 reset irq", irq_o, 1'b0);
    chk("R11 reset abort", abort_o, 1'b0);
    chk("R11 reset nullified", nullified_o, 1'b0);
    ready_in = 1'b1; waitn(4);
    chk("R11 nothing armed after reset", irq_o, 1'b0);
    ready_in = 1'b0; waitn(4);

    for (int n = 0; n < 16; n++) begin
      logic [3:0] c;
      c = 4'(n);
      wr(8'hD0); rd();
      wr({4'hD, c});
      chk("R3 R7 irq after command", irq_o, c[3]);
      if (c[3]) begin
        rd();
        chk("R9 held through read", irq_o, 1'b1);
        wr(8'hD4);
        chk("R9 held through non-D0 force write", irq_o, 1'b1);
        wr(8'hD0);
        chk("R9 D0 itself does not clear", irq_o, 1'b1);
        rd();
        chk("R9 read after D0 clears", irq_o, 1'b0);
      end else begin
        ready_in = 1'b1; waitn(3);
        chk("R4 R6 ready rise", irq_o, c[0]);
        rd();
        chk("R8 read clears", irq_o, 1'b0);
        ready_in = 1'b0; waitn(3);
        chk("R4 R6 ready fall", irq_o, c[1]);
        rd();
        index_in = 1'b1; waitn(3);
        chk("R5 R6 index rise", irq_o, c[2]);
        rd();
        waitn(3);
        chk("R5 held index no refire", irq_o, 1'b0);
        index_in = 1'b0; waitn(3);
        chk("R5 index fall no fire", irq_o, 1'b0);
        index_in = 1'b1; waitn(1); index_in = 1'b0; waitn(2);
        chk("R5 R6 second index pulse", irq_o, c[2]);
        wr(8'hD0);
        chk("R8 command write clears", irq_o, 1'b0);
      end
      waitn(NSD + 2);
    end

    seq_busy = 1'b1; alu_idle = 1'b0;
    wr(8'hD0);
    #1 chk("R2 no abort while alu busy", abort_o, 1'b0);
    waitn(3);
    chk("R2 still waiting for alu", abort_o, 1'b0);
    chk("R7 D0 raises no irq", irq_o, 1'b0);
    alu_idle = 1'b1; #1;
    chk("R1 R2 abort when alu idle", abort_o, 1'b1);
    waitn(1);
    chk("R2 abort lasts one cycle", abort_o, 1'b0);
    seq_busy = 1'b0;
    wr(8'hD4);
    #1 chk("R1 no abort when not busy", abort_o, 1'b0);
    alu_idle = 1'b0;
    waitn(NSD + 2);

    guard_case(1'b1, 0, 1'b1);
    guard_case(1'b1, NDD - 1, 1'b1);
    guard_case(1'b1, NDD, 1'b0);
    guard_case(1'b0, NSD - 1, 1'b1);
    guard_case(1'b0, NSD, 1'b0);

    wr(8'hD1);
    waitn(1);
    wr(8'h20);
    chk("R10 flag set by early write", nullified_o, 1'b1);
    wr(8'hD0);
    chk("R11 force write clears flag", nullified_o, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule